// File: doc/BRIEF.md
# 10G Ethernet Receive MAC (64-bit lane interface)

This block sits behind a 10 Gb/s reconciliation sublayer. Each clock it takes one 64-bit word of eight byte lanes, with one control flag per lane, and rebuilds the Ethernet frames carried on that bus. It forwards each frame as a stream of 64-bit beats with a per-byte keep mask, valid, last and a user error flag. The stream starts at the first destination-address byte and ends at the last payload byte. The preamble word is consumed, and the four trailing check bytes are verified and then removed. The output has no ready input, so the consumer must take one beat per cycle.

A frame opens with a start word: lane 0 carries the start control character, lanes 1 to 6 carry 0x55 and lane 7 carries 0xD5. The frame closes at the first lane that carries the terminate control character, and that lane can be any of the eight. The block holds back one full word so that the check bytes can be stripped even when they are split across two input words. When the terminate character sits in lane 5, 6 or 7, one extra tail beat is emitted on the next cycle. Two status outputs pulse for one cycle each: one for any bad frame and one for a check-sequence mismatch.

Top module: `xge_rx_mac`

## Requirements
- R1: After reset, and while only idle words (0x07 in every lane, all control flags set) arrive, m_tvalid, m_tlast, m_tuser, err_frame and err_fcs stay low.
- R2: A frame is accepted only from a word with control flags 0x01 whose bytes are 0xFB in lane 0, 0x55 in lanes 1 to 6 and 0xD5 in lane 7. A word that differs in any byte starts nothing, and the bytes that follow it produce no output and no error pulse. The start word itself is never forwarded.
- R3: Frame byte k is output in beat k/8, in lane k%8 (tdata bits 8*(k%8)+7 down to 8*(k%8)), in arrival order.
- R4: Every beat other than the last has keep 0xFF. The last beat has m_tlast set and a keep mask of contiguous low bits, one bit for each remaining byte.
- R5: The four bytes before the terminate character are removed from the stream, for a terminate character in any lane 0 to 7. The number of bytes output equals the number of bytes received minus four.
- R6: The check uses CRC-32 (reflected polynomial 0x04C11DB7, initial value all ones, check bytes sent least significant byte first) over all bytes between the start word and the terminate character. On a mismatch, m_tuser is set on the last beat, and err_frame and err_fcs both pulse in the cycle of that beat.
- R7: A control lane other than terminate inside a frame (for example 0xFE with its flag set) marks the frame bad: m_tuser is set on the last beat and err_frame pulses, while err_fcs stays low.
- R8: Frames separated by a single idle word are each received intact, and a bad frame does not disturb the good frame that follows it.
- R9: A frame that terminates before one full data word has arrived produces no output beat. It pulses err_frame only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 64 | Receive bytes, lane i in bits 8i+7:8i |
| rx_ctrl | input | 8 | Per-lane control flag |
| m_tdata | output | 64 | Output stream data |
| m_tkeep | output | 8 | Output byte keep mask |
| m_tvalid | output | 1 | Output beat valid |
| m_tlast | output | 1 | Final beat of frame |
| m_tuser | output | 1 | Frame error, meaningful on the final beat |
| err_frame | output | 1 | One-cycle pulse for any bad frame |
| err_fcs | output | 1 | One-cycle pulse for a check-sequence mismatch |

## Verification
The hardest cases to reach are the terminate positions that split the check bytes across two input words, together with the lanes 5 to 7 that need a delayed tail beat. The bench steers the terminate character through all eight lanes by sweeping the payload length from 1 to 8 bytes. It also runs a truncated frame followed directly by a good one, so that the tail beat and a new start word arrive in adjacent cycles. A control error byte is placed in the middle of a payload to show that it suppresses the check-sequence flag even though the CRC is also corrupted.

// File: rtl/xrx_pkg.sv
package xrx_pkg;
  localparam logic [7:0]  CH_START = 8'hFB;
  localparam logic [7:0]  CH_TERM  = 8'hFD;
  localparam logic [7:0]  CH_PRE   = 8'h55;
  localparam logic [7:0]  CH_SFD   = 8'hD5;
  localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;
  // Register value left after a frame and its own check bytes are absorbed
  localparam logic [31:0] CRC_GOOD = 32'hDEBB_20E3;

  // Absorb one byte into the reflected CRC register
  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/xrx_lane_scan.sv
module xrx_lane_scan import xrx_pkg::*; #(
  parameter int LANES = 8,
  localparam int DW = LANES * 8,
  localparam int LW = $clog2(LANES)
) (
  input  logic [DW-1:0]    data,
  input  logic [LANES-1:0] ctrl,
  output logic             is_start,
  output logic             has_term,
  output logic [LW:0]      term_lane,
  output logic             ctl_err
);
  always_comb begin
    has_term  = 1'b0;
    term_lane = (LW+1)'(LANES);
    for (int i = LANES - 1; i >= 0; i--) begin
      if (ctrl[i] && data[8*i +: 8] == CH_TERM) begin
        has_term  = 1'b1;
        term_lane = (LW+1)'(i);
      end
    end
  end

  // Any control lane ahead of the terminate lane is an in-frame error
  always_comb begin
    ctl_err = 1'b0;
    for (int i = 0; i < LANES; i++)
      if (ctrl[i] && ((LW+1)'(i) < term_lane)) ctl_err = 1'b1;
  end

  always_comb begin
    is_start = (ctrl == {{(LANES-1){1'b0}}, 1'b1}) && (data[7:0] == CH_START)
               && (data[DW-1 -: 8] == CH_SFD);
    for (int i = 1; i < LANES - 1; i++)
      if (data[8*i +: 8] != CH_PRE) is_start = 1'b0;
  end
endmodule

// File: rtl/xrx_crc_word.sv
module xrx_crc_word import xrx_pkg::*; #(
  parameter int LANES = 8,
  localparam int DW = LANES * 8,
  localparam int LW = $clog2(LANES)
) (
  input  logic [31:0]   crc_in,
  input  logic [DW-1:0] data,
  input  logic [LW:0]   nbytes,
  output logic [31:0]   crc_out
);
  always_comb begin
    crc_out = crc_in;
    for (int i = 0; i < LANES; i++)
      if ((LW+1)'(i) < nbytes) crc_out = crc_byte(crc_out, data[8*i +: 8]);
  end
endmodule

// File: rtl/xge_rx_mac.sv
module xge_rx_mac import xrx_pkg::*; #(
  parameter int LANES = 8,
  parameter int FCS_BYTES = 4,
  localparam int DW = LANES * 8,
  localparam int LW = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DW-1:0]    rx_data,
  input  logic [LANES-1:0] rx_ctrl,
  output logic [DW-1:0]    m_tdata,
  output logic [LANES-1:0] m_tkeep,
  output logic             m_tvalid,
  output logic             m_tlast,
  output logic             m_tuser,
  output logic             err_frame,
  output logic             err_fcs
);
  function automatic logic [LANES-1:0] keep_low(input int n);
    logic [LANES-1:0] k;
    k = '0;
    for (int i = 0; i < LANES; i++) k[i] = (i < n);
    return k;
  endfunction

  logic             in_frame, have_prev, err_q;
  logic [DW-1:0]    prev_data;
  logic [31:0]      crc_q, crc_next;
  logic             tail_pend, tail_user, tail_fcs;
  logic [DW-1:0]    tail_data;
  logic [LANES-1:0] tail_keep;

  logic             is_start, has_term, ctl_err;
  logic [LW:0]      term_lane, feed_n;
  int               term_int;

  xrx_lane_scan #(.LANES(LANES)) u_scan (
    .data(rx_data), .ctrl(rx_ctrl), .is_start(is_start),
    .has_term(has_term), .term_lane(term_lane), .ctl_err(ctl_err)
  );

  assign feed_n = has_term ? term_lane : (LW+1)'(LANES);

  xrx_crc_word #(.LANES(LANES)) u_crc (
    .crc_in(crc_q), .data(rx_data), .nbytes(feed_n), .crc_out(crc_next)
  );

  // Named events for the checker
  logic ev_start, ev_term, ev_runt, crc_bad, frm_bad, bad_any, fcs_only;
  assign ev_start = !in_frame && is_start;
  assign ev_term  = in_frame && has_term;
  assign ev_runt  = ev_term && !have_prev;
  assign crc_bad  = (crc_next != CRC_GOOD);
  assign frm_bad  = err_q | ctl_err;
  assign bad_any  = frm_bad | crc_bad;
  assign fcs_only = crc_bad & ~frm_bad;
  assign term_int = int'(term_lane);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame  <= 1'b0;
      have_prev <= 1'b0;
      err_q     <= 1'b0;
      prev_data <= '0;
      crc_q     <= CRC_INIT;
      tail_pend <= 1'b0;
      tail_user <= 1'b0;
      tail_fcs  <= 1'b0;
      tail_data <= '0;
      tail_keep <= '0;
      m_tdata   <= '0;
      m_tkeep   <= '0;
      m_tvalid  <= 1'b0;
      m_tlast   <= 1'b0;
      m_tuser   <= 1'b0;
      err_frame <= 1'b0;
      err_fcs   <= 1'b0;
    end else begin
      m_tvalid  <= 1'b0;
      m_tlast   <= 1'b0;
      m_tuser   <= 1'b0;
      err_frame <= 1'b0;
      err_fcs   <= 1'b0;
      tail_pend <= 1'b0;
      if (tail_pend) begin
        m_tvalid  <= 1'b1;
        m_tdata   <= tail_data;
        m_tkeep   <= tail_keep;
        m_tlast   <= 1'b1;
        m_tuser   <= tail_user;
        err_frame <= tail_user;
        err_fcs   <= tail_fcs;
      end
      if (!in_frame) begin
        if (is_start) begin
          in_frame  <= 1'b1;
          have_prev <= 1'b0;
          err_q     <= 1'b0;
          crc_q     <= CRC_INIT;
        end
      end else if (!has_term) begin
        crc_q     <= crc_next;
        err_q     <= frm_bad;
        prev_data <= rx_data;
        have_prev <= 1'b1;
        if (have_prev) begin
          m_tvalid <= 1'b1;
          m_tdata  <= prev_data;
          m_tkeep  <= '1;
        end
      end else begin
        in_frame <= 1'b0;
        if (!have_prev) begin
          err_frame <= 1'b1;
        end else if (term_int > FCS_BYTES) begin
          // Held word is full; the remainder follows as a tail beat
          m_tvalid  <= 1'b1;
          m_tdata   <= prev_data;
          m_tkeep   <= '1;
          tail_pend <= 1'b1;
          tail_data <= rx_data;
          tail_keep <= keep_low(term_int - FCS_BYTES);
          tail_user <= bad_any;
          tail_fcs  <= fcs_only;
        end else begin
          m_tvalid  <= 1'b1;
          m_tdata   <= prev_data;
          m_tkeep   <= keep_low(term_int + LANES - FCS_BYTES);
          m_tlast   <= 1'b1;
          m_tuser   <= bad_any;
          err_frame <= bad_any;
          err_fcs   <= fcs_only;
        end
      end
    end
  end
endmodule

// File: rtl/xrx_checker.sv
module xrx_checker #(
  parameter int LANES = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [LANES-1:0] m_tkeep,
  input logic             m_tvalid,
  input logic             m_tlast,
  input logic             m_tuser,
  input logic             err_frame,
  input logic             err_fcs,
  input logic             in_frame,
  input logic             tail_pend
);
  localparam logic [LANES-1:0] ONE = {{(LANES-1){1'b0}}, 1'b1};

  a_r1_flags_need_valid: assert property (@(posedge clk) disable iff (rst)
    !m_tvalid |-> (!m_tlast && !m_tuser));

  a_r2_no_beat_outside_frame: assert property (@(posedge clk) disable iff (rst)
    (!in_frame && !tail_pend) |=> !m_tvalid);

  a_r4_full_keep_midframe: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && !m_tlast) |-> (m_tkeep == '1));

  a_r4_keep_contiguous: assert property (@(posedge clk) disable iff (rst)
    m_tvalid |-> (m_tkeep[0] && ((m_tkeep & (m_tkeep + ONE)) == '0)));

  a_r6_fcs_implies_frame: assert property (@(posedge clk) disable iff (rst)
    err_fcs |-> err_frame);

  a_r6_fcs_on_last_beat: assert property (@(posedge clk) disable iff (rst)
    err_fcs |-> (m_tvalid && m_tlast && m_tuser));

  a_r7_user_pulses_frame: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && m_tlast && m_tuser) |-> err_frame);

  a_r8_tail_single_cycle: assert property (@(posedge clk) disable iff (rst)
    tail_pend |=> !tail_pend);
endmodule

bind xge_rx_mac xrx_checker #(.LANES(LANES)) u_chk (.*);

// File: tb/sim_xge_rx_mac.sv
`timescale 1ns/1ps
module sim_xge_rx_mac;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] rx_data = {8{8'h07}};
  logic [7:0]  rx_ctrl = 8'hFF;
  logic [63:0] m_tdata;
  logic [7:0]  m_tkeep;
  logic        m_tvalid, m_tlast, m_tuser, err_frame, err_fcs;

  xge_rx_mac u0 (.*);

  always #2 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  logic [7:0] fb [0:255];
  int fl;
  logic [7:0] sb [0:511];
  logic       sc [0:511];
  logic [7:0] rxb [0:1023];
  int rx_n, fr_done, n_ef, n_efcs, keep_bad;
  int fr_end [0:15];
  logic fr_user [0:15];
  logic [7:0] fr_keep [0:15];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst) begin
    if (m_tvalid) begin
      for (int i = 0; i < 8; i++) if (m_tkeep[i]) begin rxb[rx_n] = m_tdata[8*i +: 8]; rx_n++; end
      if (!m_tlast && m_tkeep != 8'hFF) keep_bad++;
      if (m_tlast) begin
        fr_end[fr_done] = rx_n; fr_user[fr_done] = m_tuser; fr_keep[fr_done] = m_tkeep;
        fr_done++;
      end
    end
    if (err_frame) n_ef++;
    if (err_fcs) n_efcs++;
  end

  task automatic clear_rx();
    rx_n = 0; fr_done = 0; n_ef = 0; n_efcs = 0; keep_bad = 0;
  endtask

  // Frame: addresses, type, payload 0..p-1, then reference CRC least byte first
  task automatic build(input int p);
    logic [31:0] c;
    for (int i = 0; i < 6; i++) begin fb[i] = 8'hD0 + 8'(i); fb[6+i] = 8'h50 + 8'(i); end
    fb[12] = 8'h08; fb[13] = 8'h00;
    for (int i = 0; i < p; i++) fb[14+i] = 8'(i);
    fl = 14 + p;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < fl; i++) begin
      for (int b = 0; b < 8; b++) begin
        if (c[0] ^ fb[i][b]) c = (c >> 1) ^ 32'hEDB8_8320; else c = c >> 1;
      end
    end
    c = ~c;
    for (int k = 0; k < 4; k++) fb[fl+k] = c[8*k +: 8];
  endtask

  task automatic put_word(input logic [63:0] d, input logic [7:0] c);
    @(posedge clk); #1; rx_data = d; rx_ctrl = c;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put_word({8{8'h07}}, 8'hFF);
  endtask

  task automatic send_stream(input int nb, input int err_at, input bit bad_pre, input int gap);
    int j;
    logic [63:0] d; logic [7:0] c;
    sb[0] = 8'hFB; sc[0] = 1'b1;
    for (int i = 1; i < 7; i++) begin sb[i] = 8'h55; sc[i] = 1'b0; end
    sb[7] = 8'hD5; sc[7] = 1'b0;
    if (bad_pre) sb[3] = 8'h54;
    for (int i = 0; i < nb; i++) begin sb[8+i] = fb[i]; sc[8+i] = 1'b0; end
    if (err_at >= 0) begin sb[8+err_at] = 8'hFE; sc[8+err_at] = 1'b1; end
    j = 8 + nb;
    sb[j] = 8'hFD; sc[j] = 1'b1; j++;
    while (j % 8 != 0) begin sb[j] = 8'h07; sc[j] = 1'b1; j++; end
    for (int w = 0; w < j / 8; w++) begin
      for (int l = 0; l < 8; l++) begin d[8*l +: 8] = sb[8*w+l]; c[l] = sc[8*w+l]; end
      put_word(d, c);
    end
    idle(gap);
  endtask

  task automatic cmp_bytes(input int base, input int n, input string tag);
    int bad = 0;
    for (int i = 0; i < n; i++) if (rxb[base+i] !== fb[i]) bad++;
    chk(bad == 0, tag, bad, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!m_tvalid && !m_tlast && !m_tuser, "R1 reset outputs", m_tvalid, 0);
    chk(!err_frame && !err_fcs, "R1 reset errors", err_frame, 0);
    clear_rx(); idle(10);
    chk(rx_n == 0 && n_ef == 0 && n_efcs == 0, "R1 idle quiet", rx_n, 0);
  endtask

  task automatic t_good(input int p);
    int exp_k;
    clear_rx(); build(p);
    send_stream(fl + 4, -1, 1'b0, 1); idle(4);
    exp_k = (fl % 8 == 0) ? 8 : fl % 8;
    chk(fr_done == 1, $sformatf("R5 one frame p=%0d", p), fr_done, 1);
    chk(rx_n == fl, $sformatf("R5 fcs removed p=%0d", p), rx_n, fl);
    cmp_bytes(0, fl, $sformatf("R3 byte order p=%0d", p));
    chk($countones(fr_keep[0]) == exp_k && keep_bad == 0,
        $sformatf("R4 last keep p=%0d", p), $countones(fr_keep[0]), exp_k);
    chk(!fr_user[0] && n_ef == 0 && n_efcs == 0, $sformatf("R6 no error p=%0d", p), n_ef, 0);
  endtask

  task automatic t_badfcs_then_good(input int p);
    clear_rx(); build(p);
    send_stream(fl + 3, -1, 1'b0, 1);
    send_stream(fl + 4, -1, 1'b0, 1); idle(4);
    chk(fr_done == 2, "R8 two frames", fr_done, 2);
    chk(fr_user[0] == 1'b1, "R6 user on truncated", fr_user[0], 1);
    chk(n_ef == 1 && n_efcs == 1, "R6 both pulses", n_ef * 10 + n_efcs, 11);
    chk(!fr_user[1] && fr_end[1] - fr_end[0] == fl, "R8 next frame length",
        fr_end[1] - fr_end[0], fl);
    cmp_bytes(fr_end[0], fl, "R8 next frame bytes");
  endtask

  task automatic t_xerr_then_good(input int p);
    clear_rx(); build(p);
    send_stream(fl + 4, 20, 1'b0, 1);
    send_stream(fl + 4, -1, 1'b0, 1); idle(4);
    chk(fr_done == 2 && fr_user[0], "R7 user on errored", fr_user[0], 1);
    chk(n_ef == 1 && n_efcs == 0, "R7 frame pulse only", n_ef * 10 + n_efcs, 10);
    chk(!fr_user[1], "R8 good after errored", fr_user[1], 0);
    cmp_bytes(fr_end[0], fl, "R8 bytes after errored");
  endtask

  task automatic t_runt();
    clear_rx(); build(4);
    send_stream(3, -1, 1'b0, 1); idle(4);
    chk(rx_n == 0 && fr_done == 0, "R9 runt no beat", rx_n, 0);
    chk(n_ef == 1 && n_efcs == 0, "R9 runt frame pulse", n_ef * 10 + n_efcs, 10);
  endtask

  task automatic t_badpre();
    clear_rx(); build(10);
    send_stream(fl + 4, -1, 1'b1, 1); idle(4);
    chk(rx_n == 0 && n_ef == 0 && n_efcs == 0, "R2 bad preamble ignored", rx_n, 0);
    clear_rx();
    send_stream(fl + 4, -1, 1'b0, 1); idle(4);
    chk(fr_done == 1 && rx_n == fl, "R2 recovers after bad preamble", rx_n, fl);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    clear_rx();
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    for (int p = 1; p <= 8; p++) t_good(p);
    t_good(46);
    t_good(60);
    for (int p = 5; p <= 8; p++) t_badfcs_then_good(p);
    t_badfcs_then_good(30);
    t_xerr_then_good(24);
    t_runt();
    t_badpre();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule